// File: doc/BRIEF.md
# SCSI Selection Detect Interrupt Unit

This block watches a SCSI bus for a selection phase aimed at the local device and raises an interrupt when it sees one. Every bus line is active low. Each line passes through a two-flop synchronizer and is then inverted, so inside the block a high level means asserted. Software loads a write-only ID mask. A selection is detected when three things hold together: a data line whose mask bit is set is asserted, BSY is released and SEL is asserted.

The interrupt is edge-triggered. It latches on the first cycle of a new detection and stays high until the interrupt-clear strobe arrives. An input taken from the mode register enables a parity check. When that check is enabled, bad odd parity across the data lines and the parity line raises a parity-error flag together with the interrupt.

The block also presents a live, synchronized snapshot of the eight bus control and parity lines for status reads. It does not arbitrate, reselect or drive the bus.

Top module: `sel_detect_irq`

## Requirements
- R1: The ID mask register is write-only and loads `mask_wdata` on a clock edge where `mask_we` is 1. While the mask is all zeros, `irq` never rises, whatever the bus does.
- R2: `irq` goes to 1 three clock edges after the bus inputs settle into a detection. A detection needs all of the following: at least one asserted data line whose mask bit is set, BSY released (`bus_bsy_n`=1) and SEL asserted (`bus_sel_n`=0).
- R3: `irq` does not rise in any of these cases: BSY is asserted, SEL is released, or only unmasked data lines are asserted.
- R4: The interrupt fires on the start of a detection and not on its level. A detection that is still present after a clear does not raise `irq` again. A detection that goes away and then comes back does raise it.
- R5: Once `irq` is set it stays 1 until `irq_clr` is seen on a clock edge. It is 0 after that edge unless a new detection starts on the same edge.
- R6: Parity is odd: the number of asserted lines among the eight data lines and the parity line must be odd. If `par_chk_en` is 1 at the edge where a detection starts and the parity is even, `par_err` goes to 1 along with `irq`. If `par_chk_en` is 0 at that edge, `par_err` stays 0.
- R7: `par_err` stays set until `irq_clr` is seen on a clock edge, and it is never 1 while `irq` is 0.
- R8: `bus_snap` shows the synchronized bus lines true-high, two clock edges after they change. The bit order is: 0 parity, 1 SEL, 2 I/O, 3 C/D, 4 MSG, 5 REQ, 6 BSY, 7 bus RST.
- R9: `rst_n` low clears the mask, `irq`, `par_err` and the snapshot. The bus RST line only shows up in the snapshot: it clears neither the mask nor a pending interrupt.
- R10: When a new detection starts on the same edge that sees `irq_clr`, the set wins and `irq` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Device reset, active low, asynchronous |
| bus_db_n | input | 8 | SCSI data lines, active low |
| bus_dbp_n | input | 1 | SCSI data parity line, active low |
| bus_sel_n | input | 1 | SCSI SEL, active low |
| bus_bsy_n | input | 1 | SCSI BSY, active low |
| bus_io_n | input | 1 | SCSI I/O, active low |
| bus_cd_n | input | 1 | SCSI C/D, active low |
| bus_msg_n | input | 1 | SCSI MSG, active low |
| bus_req_n | input | 1 | SCSI REQ, active low |
| line_rst_n | input | 1 | SCSI bus RST line, active low |
| mask_we | input | 1 | Write strobe for the ID mask |
| mask_wdata | input | 8 | New ID mask value |
| par_chk_en | input | 1 | Parity check enable from the mode register |
| irq_clr | input | 1 | Interrupt clear strobe, from the reset-interrupt read |
| irq | output | 1 | Selection interrupt request |
| par_err | output | 1 | Parity error seen during the latched selection |
| bus_snap | output | 8 | Synchronized true-high bus status snapshot |

## Verification
The bench targets the following behaviours; each entry says what a faulty design would show:
- **Persistent detection after a clear.** A level-triggered design would raise the interrupt again.
- **Set on the same edge as a clear.** If clear had priority, a new selection would be lost.
- **Latency.** A design with the wrong synchronizer depth would show `irq` or the snapshot one edge early or late.
- **Parity.** A design that checked even parity would flag the good frames and pass the bad ones. A design that ignored the enable would report errors with checking turned off.
- **Reset and the mask.** A design that let the bus RST line clear the mask would miss a later selection. A design that kept the mask across a device reset would fire with no mask loaded.

// File: rtl/sdi_pkg.sv
package sdi_pkg;
   // Control and parity lines, packed so the bit position is the snapshot position.
   typedef struct packed {
      logic rst;
      logic bsy;
      logic req;
      logic msg;
      logic cd;
      logic io;
      logic sel;
      logic dbp;
   } sdi_ctl_t;

   localparam int SDI_CTL_W = $bits(sdi_ctl_t);
endpackage

// File: rtl/sdi_sync.sv
module sdi_sync #(
   parameter int W      = 16,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din_n,
   output logic [W-1:0] dout
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("sdi_sync needs at least two stages");
      end
      if (W < 1) begin : g_bad_width
         $error("sdi_sync width must be positive");
      end
   endgenerate

   logic [STAGES-1:0][W-1:0] stg_q;

   // Lines are inverted on entry, so the chain holds true-high values.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q <= '0;
      else        stg_q <= {stg_q[STAGES-2:0], ~din_n};
   end

   assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/sdi_parity.sv
module sdi_parity #(
   parameter int W   = 8,
   parameter bit ODD = 1'b1
) (
   input  logic [W-1:0] data,
   input  logic         par,
   output logic         ok
);
   logic ones_odd;
   assign ones_odd = ^{data, par};

   generate
      if (ODD) begin : g_odd
         assign ok = ones_odd;
      end else begin : g_even
         assign ok = ~ones_odd;
      end
   endgenerate
endmodule

// File: rtl/sdi_detect.sv
module sdi_detect #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] db,
   input  logic [W-1:0] mask,
   input  logic         sel,
   input  logic         bsy,
   input  logic         par_ok,
   input  logic         chk_en,
   input  logic         clr,
   output logic         irq,
   output logic         perr
);
   logic hit_c, rise_c, match_q, irq_q, perr_q;

   assign hit_c  = (|(db & mask)) & sel & ~bsy;
   assign rise_c = hit_c & ~match_q;

   // A new detection takes priority over a clear on the same edge.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         match_q <= 1'b0;
         irq_q   <= 1'b0;
         perr_q  <= 1'b0;
      end else begin
         match_q <= hit_c;
         irq_q   <= rise_c | (irq_q & ~clr);
         perr_q  <= (rise_c & chk_en & ~par_ok) | (perr_q & ~clr);
      end
   end

   assign irq  = irq_q;
   assign perr = perr_q;

   AST_IRQ_HOLD:    assert property (@(posedge clk) disable iff (!rst_n) irq_q && !clr |=> irq_q);         // R5
   AST_IRQ_CLEAR:   assert property (@(posedge clk) disable iff (!rst_n) clr && !rise_c |=> !irq_q);       // R5
   AST_PERR_NO_CHK: assert property (@(posedge clk) disable iff (!rst_n) !chk_en && !perr_q |=> !perr_q);  // R6
   AST_PERR_IRQ:    assert property (@(posedge clk) disable iff (!rst_n) perr_q |-> irq_q);                // R7
endmodule

// File: rtl/sel_detect_irq.sv
module sel_detect_irq
   import sdi_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit ODD_PARITY  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] bus_db_n,
   input  logic              bus_dbp_n,
   input  logic              bus_sel_n,
   input  logic              bus_bsy_n,
   input  logic              bus_io_n,
   input  logic              bus_cd_n,
   input  logic              bus_msg_n,
   input  logic              bus_req_n,
   input  logic              line_rst_n,
   input  logic              mask_we,
   input  logic [DATA_W-1:0] mask_wdata,
   input  logic              par_chk_en,
   input  logic              irq_clr,
   output logic              irq,
   output logic              par_err,
   output logic [SDI_CTL_W-1:0] bus_snap
);
   localparam int SYNC_W = DATA_W + SDI_CTL_W;

   generate
      if (DATA_W < 1 || DATA_W > 32) begin : g_bad_data_w
         $error("sel_detect_irq data width out of range");
      end
   endgenerate

   logic [DATA_W-1:0] mask_q;
   logic [SYNC_W-1:0] raw_n, sync_s;
   logic [DATA_W-1:0] db_s;
   sdi_ctl_t          ctl_s;
   logic              par_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mask_q <= '0;
      else if (mask_we) mask_q <= mask_wdata;
   end

   assign raw_n = {line_rst_n, bus_bsy_n, bus_req_n, bus_msg_n,
                   bus_cd_n, bus_io_n, bus_sel_n, bus_dbp_n, bus_db_n};

   sdi_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din_n(raw_n), .dout(sync_s)
   );

   assign db_s     = sync_s[DATA_W-1:0];
   assign ctl_s    = sdi_ctl_t'(sync_s[SYNC_W-1:DATA_W]);
   assign bus_snap = sync_s[SYNC_W-1:DATA_W];

   sdi_parity #(.W(DATA_W), .ODD(ODD_PARITY)) u_par (
      .data(db_s), .par(ctl_s.dbp), .ok(par_ok)
   );

   sdi_detect #(.W(DATA_W)) u_det (
      .clk(clk), .rst_n(rst_n), .db(db_s), .mask(mask_q),
      .sel(ctl_s.sel), .bsy(ctl_s.bsy), .par_ok(par_ok),
      .chk_en(par_chk_en), .clr(irq_clr), .irq(irq), .perr(par_err)
   );

   AST_ZERO_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q == '0) && !irq |=> !irq);                                                 // R1
   AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(ctl_s.sel && !ctl_s.bsy && (|(db_s & mask_q))));            // R2
   AST_PERR_WITH_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(par_err) |-> $rose(irq));                                                   // R6
endmodule

// File: tb/sel_detect_irq_tb.sv
module sel_detect_irq_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] db_n = 8'hFF;
   logic       dbp_n = 1'b1, sel_n = 1'b1, bsy_n = 1'b1, io_n = 1'b1;
   logic       cd_n = 1'b1, msg_n = 1'b1, req_n = 1'b1, lrst_n = 1'b1;
   logic       mask_we = 1'b0, par_chk_en = 1'b0, irq_clr = 1'b0;
   logic [7:0] mask_wdata = 8'h00;
   logic       irq, par_err;
   logic [7:0] bus_snap;

   int total = 0, bad = 0, cyc = 0;
   string cur_req = "R9";

   always #2.5 clk = ~clk;

   sel_detect_irq dut_i (
      .clk(clk), .rst_n(rst_n), .bus_db_n(db_n), .bus_dbp_n(dbp_n),
      .bus_sel_n(sel_n), .bus_bsy_n(bsy_n), .bus_io_n(io_n), .bus_cd_n(cd_n),
      .bus_msg_n(msg_n), .bus_req_n(req_n), .line_rst_n(lrst_n),
      .mask_we(mask_we), .mask_wdata(mask_wdata), .par_chk_en(par_chk_en),
      .irq_clr(irq_clr), .irq(irq), .par_err(par_err), .bus_snap(bus_snap)
   );

   // Reference model: behaviour taken from the requirements.
   logic [15:0] hist[$];
   logic [7:0]  m_mask = 8'h00;
   bit          m_match = 0, m_irq = 0, m_perr = 0;
   logic [7:0]  m_snap = 8'h00;

   function automatic bit odd_ok(logic [8:0] v);
      int n = 0;
      for (int i = 0; i < 9; i++) if (v[i]) n++;
      return (n % 2) == 1;
   endfunction

   initial begin
      hist.push_back(16'hFFFF);
      hist.push_back(16'hFFFF);
   end

   always @(posedge clk) begin
      if (!rst_n) begin
         hist.delete();
         hist.push_back(16'hFFFF);
         hist.push_back(16'hFFFF);
         m_mask = 0; m_match = 0; m_irq = 0; m_perr = 0; m_snap = 0;
      end else begin
         logic [15:0] t;
         bit hit, rise;
         t    = ~hist[0];
         hit  = ((t[7:0] & m_mask) != 0) && t[9] && !t[14];
         rise = hit && !m_match;
         m_match = hit;
         m_perr  = (rise && par_chk_en && !odd_ok(t[8:0])) || (m_perr && !irq_clr);
         m_irq   = rise || (m_irq && !irq_clr);
         if (mask_we) m_mask = mask_wdata;
         hist.push_back({lrst_n, bsy_n, req_n, msg_n, cd_n, io_n, sel_n, dbp_n, db_n});
         void'(hist.pop_front());
         t      = ~hist[0];
         m_snap = t[15:8];
      end
   end

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp, string what);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      chk(cur_req, irq, m_irq, "model irq");
      chk(cur_req, par_err, m_perr, "model par_err");
      chk(cur_req, bus_snap, m_snap, "model snapshot");
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         total++; bad++;
         $display("FAIL watchdog: actual=%0d expected<=20000", cyc);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic drive_sel(logic [7:0] id, bit good_par);
      bit p;
      @(negedge clk); #1;
      p = odd_ok({1'b0, id}) ? 1'b0 : 1'b1;
      if (!good_par) p = ~p;
      db_n = ~id; dbp_n = ~p; sel_n = 1'b0; bsy_n = 1'b1;
   endtask

   task automatic idle_bus();
      @(negedge clk); #1;
      db_n = 8'hFF; dbp_n = 1'b1; sel_n = 1'b1; bsy_n = 1'b1;
      io_n = 1'b1; cd_n = 1'b1; msg_n = 1'b1; req_n = 1'b1; lrst_n = 1'b1;
   endtask

   task automatic write_mask(logic [7:0] v);
      @(negedge clk); #1; mask_we = 1'b1; mask_wdata = v;
      @(negedge clk); #1; mask_we = 1'b0;
   endtask

   task automatic clear_irq();
      @(negedge clk); #1; irq_clr = 1'b1;
      @(negedge clk); #1; irq_clr = 1'b0;
   endtask

   initial begin
      tick(3);
      cur_req = "R9";
      chk("R9", irq, 0, "irq after reset");
      chk("R9", par_err, 0, "par_err after reset");
      chk("R9", bus_snap, 0, "snapshot after reset");
      @(negedge clk); #1; rst_n = 1'b1;

      cur_req = "R1";
      drive_sel(8'h08, 1);
      tick(6);
      chk("R1", irq, 0, "zero mask stays quiet");
      idle_bus(); tick(4);

      cur_req = "R2";
      write_mask(8'h08);
      drive_sel(8'h08, 1);
      tick(2);
      chk("R2", irq, 0, "irq not yet after two edges");
      tick(1);
      chk("R2", irq, 1, "irq after three edges");
      chk("R2", par_err, 0, "good parity");

      cur_req = "R5";
      tick(5);
      chk("R5", irq, 1, "irq held");
      clear_irq();
      chk("R5", irq, 0, "irq cleared");

      cur_req = "R4";
      tick(5);
      chk("R4", irq, 0, "persistent detection does not refire");
      idle_bus(); tick(4);
      drive_sel(8'h08, 1); tick(3);
      chk("R4", irq, 1, "new detection refires");
      clear_irq(); idle_bus(); tick(4);

      cur_req = "R3";
      drive_sel(8'h08, 1); bsy_n = 1'b0; tick(5);
      chk("R3", irq, 0, "BSY asserted blocks");
      idle_bus(); @(negedge clk); #1; db_n = ~8'h08; tick(5);
      chk("R3", irq, 0, "SEL released blocks");
      idle_bus(); drive_sel(8'h30, 1); tick(5);
      chk("R3", irq, 0, "unmasked ID blocks");
      idle_bus(); tick(4);

      cur_req = "R6";
      par_chk_en = 1'b1;
      drive_sel(8'h09, 0); tick(3);
      chk("R6", irq, 1, "irq with bad parity");
      chk("R6", par_err, 1, "parity error flagged");

      cur_req = "R7";
      tick(3);
      chk("R7", par_err, 1, "par_err held");
      clear_irq();
      chk("R7", par_err, 0, "par_err cleared");
      idle_bus(); tick(4);

      cur_req = "R6";
      par_chk_en = 1'b0;
      drive_sel(8'h09, 0); tick(3);
      chk("R6", irq, 1, "irq with check off");
      chk("R6", par_err, 0, "no error when check off");
      clear_irq(); idle_bus(); tick(4);
      par_chk_en = 1'b1;
      drive_sel(8'h0C, 1); tick(3);
      chk("R6", par_err, 0, "odd parity accepted");
      clear_irq(); idle_bus(); tick(4);
      par_chk_en = 1'b0;

      cur_req = "R8";
      for (int b = 0; b < 8; b++) begin
         idle_bus();
         case (b)
            0: dbp_n = 1'b0; 1: sel_n = 1'b0; 2: io_n = 1'b0; 3: cd_n = 1'b0;
            4: msg_n = 1'b0; 5: req_n = 1'b0; 6: bsy_n = 1'b0; default: lrst_n = 1'b0;
         endcase
         tick(2);
         chk("R8", bus_snap, 8'h01 << b, "snapshot bit");
      end
      idle_bus(); tick(4);

      cur_req = "R10";
      drive_sel(8'h08, 1); tick(2);
      #1; irq_clr = 1'b1;
      tick(1); #1; irq_clr = 1'b0;
      chk("R10", irq, 1, "set wins over clear");
      clear_irq(); idle_bus(); tick(4);

      cur_req = "R9";
      @(negedge clk); #1; lrst_n = 1'b0;
      drive_sel(8'h08, 1); tick(3);
      chk("R9", irq, 1, "bus RST keeps mask");
      tick(2);
      chk("R9", irq, 1, "bus RST keeps pending irq");
      idle_bus();
      @(negedge clk); #1; rst_n = 1'b0;
      tick(2); #1; rst_n = 1'b1;
      chk("R9", irq, 0, "device reset clears irq");
      drive_sel(8'h08, 1); tick(5);
      chk("R9", irq, 0, "device reset cleared mask");
      idle_bus(); tick(3);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule